// File: doc/BRIEF.md
# Pipelined Burst Static Memory Core

This block is a synchronous static memory with a two-stage register pipeline and a four-beat burst address generator. Each rising clock edge is decoded from two address strobes into one command: deselect, begin read, begin write, continue the burst, or suspend it. The two strobes are a processor strobe and a controller strobe, and they obey different gating rules. The block has three chip enables: a master enable (active low), a secondary enable that is active high, and a secondary enable that is active low.

Writes take effect on the edge that samples them. A global write enable writes the whole 32-bit word. Otherwise a byte-write enable, together with one enable per byte lane, writes only the selected lanes. A read registers its address on one edge, and the word appears on the output register after the next edge. The tri-state enable for the data bus is brought out as a separate output and is gated combinationally by the output enable. Deselection reaches the data bus through both pipeline stages, so the bus is released two edges after the deselect command.

Top module: `psb_core`

## Requirements
- R1: When the processor strobe is low and the master enable is low, the edge begins a read at the external address, whatever the write enables and the controller strobe are doing. No byte of the array is written on that edge.
- R2: When the master enable is high, a low processor strobe is ignored. If the controller strobe is also high, the edge acts as a plain continue or suspend of the burst in progress.
- R3: The controller strobe begins a cycle only if the processor strobe is high on the same edge. The write enables on that edge choose write or read. If the master enable is high, a low controller strobe deselects the block.
- R4: A low global write enable writes all four lanes. When it is high, the lanes written are the lanes whose per-lane enable is low, and only while the byte-write enable is low. With no lane selected, the cycle is a read. Lane n is data bits [8n+7:8n].
- R5: Read data for an address registered on edge k is present on rdata_o, with drive_o high, after edge k+1. It is not present after edge k.
- R6: Continue edges step a 2-bit beat count through 1, 2 and 3. The low two address bits are start XOR count when burst_linear_i=0 and start+count mod 4 when burst_linear_i=1. The upper bits stay fixed.
- R7: A continue edge advances the address and a suspend edge (advance input high) repeats it. Either kind of edge is a write when a write enable is active and a read otherwise.
- R8: drive_o is high only when oe_n_i is low and the output stage holds read data. It drops without a clock edge when oe_n_i rises. It is low after any edge that sampled a write.
- R9: After a deselect on edge k, drive_o still reflects the previous read after edge k and is low after edge k+1.
- R10: A strobe that begins a cycle while a secondary enable is inactive (cs_hi_i=0 or cs_lo_n_i=1) deselects the block. No write occurs and no burst stays active.
- R11: After reset drive_o is low, and continue or suspend edges do nothing until a cycle is begun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | External word address |
| strb_p_n_i | input | 1 | Processor address strobe, active low |
| strb_c_n_i | input | 1 | Controller address strobe, active low |
| cs_main_n_i | input | 1 | Master chip enable, active low |
| cs_hi_i | input | 1 | Secondary chip enable, active high |
| cs_lo_n_i | input | 1 | Secondary chip enable, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| gwe_n_i | input | 1 | Global write enable, active low |
| bwe_n_i | input | 1 | Byte-write enable, active low |
| be_n_i | input | DW/8 | Per-lane write enables, active low |
| oe_n_i | input | 1 | Output enable, active low, asynchronous |
| burst_linear_i | input | 1 | 1 selects linear order, 0 selects interleaved order |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Registered read data |
| drive_o | output | 1 | Tri-state enable for the data bus |

## Verification
The bench starts bursts at low address 1, where the interleaved order (1,0,3,2) and the linear order (1,2,3,0) differ. A sequencer that used the wrong order, or that advanced on a suspend, would return the wrong word on some beat. It opens a read with the processor strobe while the global write enable and the controller strobe are both low, and then reads the word back. A design that honoured the write enables on that edge would corrupt the word. A read followed by a continue write, and then a byte-masked suspend write, checks three things: that the bus is released while a read word still sits in the output stage, that the write went to the next beat address, and that only one lane changed on the repeat. Deselect timing, enable gating and cycles with no lane selected are each checked on the exact edge, so a design off by one stage would fail.

// File: rtl/psb_pkg.sv
package psb_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_DESEL,
    OP_BEGIN_RD,
    OP_BEGIN_WR,
    OP_CONT,
    OP_SUSP
  } psb_op_e;
endpackage

// File: rtl/psb_decode.sv
module psb_decode
  import psb_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic             strb_p_n_i,
  input  logic             strb_c_n_i,
  input  logic             cs_main_n_i,
  input  logic             cs_hi_i,
  input  logic             cs_lo_n_i,
  input  logic             adv_n_i,
  input  logic             gwe_n_i,
  input  logic             bwe_n_i,
  input  logic [LANES-1:0] be_n_i,
  output psb_op_e          op_o,
  output logic [LANES-1:0] wr_mask_o
);
  logic [LANES-1:0] mask_req;
  logic             sel_ok;

  always_comb begin
    if (!gwe_n_i)      mask_req = '1;
    else if (!bwe_n_i) mask_req = ~be_n_i;
    else               mask_req = '0;
  end

  assign sel_ok = !cs_main_n_i && cs_hi_i && !cs_lo_n_i;

  always_comb begin
    op_o      = OP_IDLE;
    wr_mask_o = '0;
    if (!strb_p_n_i && !cs_main_n_i) begin
      // processor strobe: always a read, write enables ignored
      op_o = sel_ok ? OP_BEGIN_RD : OP_DESEL;
    end else if (!strb_c_n_i) begin
      if (!sel_ok) begin
        op_o = OP_DESEL;
      end else begin
        op_o      = (|mask_req) ? OP_BEGIN_WR : OP_BEGIN_RD;
        wr_mask_o = mask_req;
      end
    end else begin
      op_o      = adv_n_i ? OP_SUSP : OP_CONT;
      wr_mask_o = mask_req;
    end
  end
endmodule

// File: rtl/psb_burst_seq.sv
module psb_burst_seq #(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic          linear_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] eff_addr_o,
  output logic [1:0]    cnt_o
);
  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  logic [1:0]    cnt_nxt;
  logic [1:0]    low_bits;

  assign cnt_nxt  = step_i ? cnt_q + 2'd1 : cnt_q;
  assign low_bits = linear_i ? (base_q[1:0] + cnt_nxt) : (base_q[1:0] ^ cnt_nxt);
  assign eff_addr_o = load_i ? addr_i : {base_q[AW-1:2], low_bits};
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      base_q <= addr_i;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_nxt;
    end
  end
endmodule

// File: rtl/psb_array.sv
module psb_array #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [DW/8-1:0] we_mask_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            re_i,
  input  logic [AW-1:0]   raddr_i,
  output logic [DW-1:0]   rdata_o
);
  localparam int unsigned LANES = DW / 8;
  localparam int unsigned DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (we_mask_i[g]) mem[waddr_i] <= wdata_i[8*g +: 8];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   rd_q <= '0;
      else if (re_i) rd_q <= mem[raddr_i];
    end

    assign rdata_o[8*g +: 8] = rd_q;
  end
endmodule

// File: rtl/psb_core.sv
module psb_core
  import psb_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic            strb_p_n_i,
  input  logic            strb_c_n_i,
  input  logic            cs_main_n_i,
  input  logic            cs_hi_i,
  input  logic            cs_lo_n_i,
  input  logic            adv_n_i,
  input  logic            gwe_n_i,
  input  logic            bwe_n_i,
  input  logic [DW/8-1:0] be_n_i,
  input  logic            oe_n_i,
  input  logic            burst_linear_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            drive_o
);
  localparam int unsigned LANES = DW / 8;

  psb_op_e          op;
  logic [LANES-1:0] wr_mask;
  logic             active_q;
  logic             live;
  logic             do_rd;
  logic             do_wr;
  logic             load;
  logic             step;
  logic [AW-1:0]    eff_addr;
  logic [1:0]       cnt_q;
  logic             rd_q;
  logic [AW-1:0]    rd_addr_q;
  logic             wr_blk_q;
  logic             out_rd_q;

  psb_decode #(.LANES(LANES)) u_dec (
    .strb_p_n_i  (strb_p_n_i),
    .strb_c_n_i  (strb_c_n_i),
    .cs_main_n_i (cs_main_n_i),
    .cs_hi_i     (cs_hi_i),
    .cs_lo_n_i   (cs_lo_n_i),
    .adv_n_i     (adv_n_i),
    .gwe_n_i     (gwe_n_i),
    .bwe_n_i     (bwe_n_i),
    .be_n_i      (be_n_i),
    .op_o        (op),
    .wr_mask_o   (wr_mask)
  );

  assign live  = active_q && (op == OP_CONT || op == OP_SUSP);
  assign load  = (op == OP_BEGIN_RD) || (op == OP_BEGIN_WR);
  assign step  = live && (op == OP_CONT);
  assign do_rd = (op == OP_BEGIN_RD) || (live && !(|wr_mask));
  assign do_wr = (op == OP_BEGIN_WR) || (live && (|wr_mask));

  psb_burst_seq #(.AW(AW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .step_i     (step),
    .linear_i   (burst_linear_i),
    .addr_i     (addr_i),
    .eff_addr_o (eff_addr),
    .cnt_o      (cnt_q)
  );

  psb_array #(.AW(AW), .DW(DW)) u_arr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_mask_i (do_wr ? wr_mask : '0),
    .waddr_i   (eff_addr),
    .wdata_i   (wdata_i),
    .re_i      (rd_q),
    .raddr_i   (rd_addr_q),
    .rdata_o   (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      rd_q      <= 1'b0;
      rd_addr_q <= '0;
      wr_blk_q  <= 1'b0;
      out_rd_q  <= 1'b0;
    end else begin
      if (load)                 active_q <= 1'b1;
      else if (op == OP_DESEL)  active_q <= 1'b0;
      rd_q     <= do_rd;
      wr_blk_q <= do_wr;
      if (do_rd) rd_addr_q <= eff_addr;
      out_rd_q <= rd_q;
    end
  end

  // output enable acts without a register
  assign drive_o = !oe_n_i && out_rd_q && !wr_blk_q;
endmodule

// File: rtl/psb_core_chk.sv
module psb_core_chk
  import psb_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       oe_n_i,
  input logic       drive_o,
  input psb_op_e    op,
  input logic       do_rd,
  input logic       do_wr,
  input logic       out_rd_q,
  input logic       active_q,
  input logic [1:0] cnt_q
);
  AST_OE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_n_i |-> !drive_o); // R8
  AST_WR_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_wr |=> !drive_o); // R8
  AST_DESEL_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_DESEL) |=> ##1 !drive_o); // R9
  AST_RD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_rd |=> ##1 out_rd_q); // R5
  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(do_rd && do_wr)); // R4
  AST_SUSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_SUSP && active_q) |=> $stable(cnt_q)); // R7
  AST_DESEL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_DESEL) |=> !active_q); // R10
endmodule

bind psb_core psb_core_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .oe_n_i   (oe_n_i),
  .drive_o  (drive_o),
  .op       (op),
  .do_rd    (do_rd),
  .do_wr    (do_wr),
  .out_rd_q (out_rd_q),
  .active_q (active_q),
  .cnt_q    (cnt_q)
);

// File: tb/tb_psb_core.sv
module tb_psb_core;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr;
  logic          strb_p_n, strb_c_n, cs_main_n, cs_hi, cs_lo_n, adv_n;
  logic          gwe_n, bwe_n, oe_n, lin;
  logic [3:0]    be_n;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          drive;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;
  logic [DW-1:0] ref_mem [1<<AW];

  always #4 clk = ~clk;

  psb_core #(.AW(AW), .DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr),
    .strb_p_n_i(strb_p_n), .strb_c_n_i(strb_c_n), .cs_main_n_i(cs_main_n),
    .cs_hi_i(cs_hi), .cs_lo_n_i(cs_lo_n), .adv_n_i(adv_n),
    .gwe_n_i(gwe_n), .bwe_n_i(bwe_n), .be_n_i(be_n), .oe_n_i(oe_n),
    .burst_linear_i(lin), .wdata_i(wdata), .rdata_o(rdata), .drive_o(drive)
  );

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    strb_p_n = 1; strb_c_n = 1; cs_main_n = 0; cs_hi = 1; cs_lo_n = 0;
    adv_n = 1; gwe_n = 1; bwe_n = 1; be_n = 4'hF; oe_n = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic desel();
    idle(); strb_c_n = 0; cs_main_n = 1; step(); idle();
  endtask

  task automatic wr_word(logic [AW-1:0] a, logic [DW-1:0] d, logic g, logic b, logic [3:0] e);
    idle(); strb_c_n = 0; addr = a; wdata = d; gwe_n = g; bwe_n = b; be_n = e;
    step();
    for (int l = 0; l < 4; l++)
      if (!g || (!b && !e[l])) ref_mem[a][8*l +: 8] = d[8*l +: 8];
    desel();
  endtask

  task automatic rd_word(logic [AW-1:0] a, bit use_c, string tag);
    desel();
    if (use_c) begin strb_c_n = 0; bwe_n = 0; be_n = 4'hF; end
    else strb_p_n = 0;
    addr = a;
    step();
    check({tag, " not yet driven (R5)"}, {31'd0, drive}, 32'd0);
    idle();
    step();
    check({tag, " drive (R5)"}, {31'd0, drive}, 32'd1);
    check({tag, " data (R5)"}, rdata, ref_mem[a]);
    desel();
  endtask

  task automatic t_reset();
    idle(); adv_n = 0; step(); step();
    check("R11 no burst after reset", {31'd0, drive}, 32'd0);
    desel();
  endtask

  task automatic t_writes();
    wr_word(8'h10, 32'hA5A5_0F0F, 0, 1, 4'hF);
    rd_word(8'h10, 0, "R4 global write");
    wr_word(8'h10, 32'h1122_3344, 1, 0, 4'b1010);
    check("R4 lane model", ref_mem[8'h10], 32'hA522_0F44);
    rd_word(8'h10, 0, "R4 lanes 0 and 2 written");
    wr_word(8'h10, 32'h0, 1, 1, 4'h0);
    rd_word(8'h10, 1, "R4 R3 byte enable high is a read");
    check("R4 unchanged", rdata, 32'hA522_0F44);
  endtask

  task automatic t_p_ignores_we();
    desel();
    strb_p_n = 0; strb_c_n = 0; gwe_n = 0; addr = 8'h10; wdata = 32'hFFFF_FFFF;
    step(); idle(); step();
    check("R1 processor strobe reads", rdata, 32'hA522_0F44);
    rd_word(8'h10, 0, "R1 word not written");
  endtask

  task automatic t_burst(logic [AW-1:0] s, bit linear, string tag);
    logic [AW-1:0] a;
    desel(); lin = linear; strb_p_n = 0; addr = s;
    step(); idle(); adv_n = 0;
    for (int i = 0; i < 4; i++) begin
      if (i == 3) adv_n = 1;
      step();
      a = {s[AW-1:2], linear ? 2'(s[1:0] + 2'(i)) : 2'(s[1:0] ^ 2'(i))};
      check({tag, " R6 beat"}, rdata, ref_mem[a]);
    end
    step();
    check({tag, " R7 suspend repeats"}, rdata, ref_mem[a]);
    desel(); lin = 0;
  endtask

  task automatic t_blocked_p();
    desel(); lin = 1; strb_p_n = 0; addr = 8'h20;
    step();
    strb_p_n = 0; cs_main_n = 1; adv_n = 0; addr = 8'h2C;
    step();
    check("R2 blocked strobe keeps bus", {31'd0, drive}, 32'd1);
    check("R2 first beat", rdata, ref_mem[8'h20]);
    idle(); step();
    check("R2 acted as continue", rdata, ref_mem[8'h21]);
    desel(); lin = 0;
  endtask

  task automatic t_cont_write();
    desel(); strb_p_n = 0; addr = 8'h30;
    step();
    idle(); adv_n = 0; bwe_n = 0; be_n = 4'h0; wdata = 32'hCAFE_0001;
    step();
    check("R8 write releases bus", {31'd0, drive}, 32'd0);
    ref_mem[8'h31] = 32'hCAFE_0001;
    adv_n = 1; be_n = 4'b1110; wdata = 32'h0000_00EE;
    step();
    check("R8 suspend write bus off", {31'd0, drive}, 32'd0);
    ref_mem[8'h31][7:0] = 8'hEE;
    desel();
    rd_word(8'h31, 0, "R7 continue then suspend write");
    check("R7 merged value", rdata, 32'hCAFE_00EE);
    rd_word(8'h30, 0, "R7 start word untouched");
    rd_word(8'h32, 0, "R7 no advance on suspend");
  endtask

  task automatic t_oe();
    desel(); strb_p_n = 0; addr = 8'h10;
    step(); idle(); oe_n = 1;
    step();
    check("R8 oe high blocks", {31'd0, drive}, 32'd0);
    oe_n = 0; #1;
    check("R8 oe acts without edge", {31'd0, drive}, 32'd1);
    desel();
  endtask

  task automatic t_dcd();
    desel(); strb_p_n = 0; addr = 8'h10;
    step(); idle(); step();
    strb_c_n = 0; cs_main_n = 1;
    step();
    check("R9 R3 still driven after deselect edge", {31'd0, drive}, 32'd1);
    idle();
    step();
    check("R9 released one edge later", {31'd0, drive}, 32'd0);
  endtask

  task automatic t_sec_enables();
    desel(); strb_c_n = 0; cs_hi = 0; gwe_n = 0; addr = 8'h10; wdata = 32'hDEAD_BEEF;
    step(); idle(); step();
    check("R10 no drive", {31'd0, drive}, 32'd0);
    strb_p_n = 0; cs_lo_n = 1; addr = 8'h10;
    step(); idle(); step(); step();
    check("R10 secondary enable deselects", {31'd0, drive}, 32'd0);
    rd_word(8'h10, 0, "R10 no write");
  endtask

  initial begin
    idle(); addr = '0; wdata = '0; lin = 0;
    repeat (3) @(negedge clk);
    check("R11 reset drive", {31'd0, drive}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_writes();
    t_p_ignores_we();
    for (int i = 0; i < 4; i++) wr_word(8'h20 + 8'(i), 32'h5000_0000 + 32'(i), 0, 1, 4'hF);
    for (int i = 0; i < 3; i++) wr_word(8'h30 + 8'(i), 32'h6000_0000 + 32'(i), 0, 1, 4'hF);
    t_burst(8'h21, 0, "interleaved");
    t_burst(8'h21, 1, "linear");
    t_blocked_p();
    t_cont_write();
    t_oe();
    t_dcd();
    t_sec_enables();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule